// File: doc/BRIEF.md
# Upset Injection Scheduler

This block picks the moment and the place at which a single-bit upset is planted in a running target. It then carries the corruption out. A run begins with a start strobe. The block latches an injection instant, a target address and a one-hot bit mask, and counts clock cycles from the start. When the count reaches the chosen instant, it raises an interrupt to the target processor. Once the target acknowledges, the block reads the addressed byte over a shared memory port, flips the masked bit by XOR and writes the byte back. It then pulses a completion flag.

The block has three ways to choose the instant and the address. In pseudo-random mode both come from a 32-bit maximal-length shift register, scaled into a programmed run length and a programmed address window. In deterministic mode both are taken from input pins. In exhaustive mode the address is fixed and the instant moves forward by exactly one cycle on every run. Repeated exhaustive runs therefore map the cycles in which a given location is sensitive. If the interrupt is never acknowledged, a timeout withdraws it and flags an error. The whole sequence, from acknowledge to completion, takes a fixed few cycles, whatever the target program is doing.

Top module: `upset_inject_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, irqReq, memRd, memWr, done and timeoutErr are all 0.
- R2: modeSel encodes the mode: 0 is pseudo-random, 1 is deterministic, 2 is exhaustive. A start is sampled only in the idle state. If the instant selected for the run is T, irqReq first goes high in the cycle that follows the (T+2)-th rising edge, counting the edge that samples start as the first; that is, T+1 edges after start. In deterministic mode T = detTime and the address is detAddr.
- R3: The pseudo-random source is a 32-bit Galois shift register. One step shifts right by one bit and, when the bit shifted out is 1, XORs the result with 32'h80200003. On the first edge after reset the register loads seed, or 1 if seed is 0. Each pseudo-random start takes exactly one step and uses the stepped value V.
- R4: In pseudo-random mode T = (V[15:0] * runLen) >> 16. The address is (addrBase + ((V[31:24] * addrSpan) >> 8)) mod 256. So T lies in 0..runLen-1, and the address lies in the window of addrSpan bytes starting at addrBase.
- R5: In exhaustive mode the address is detAddr. The instant is a sweep offset that starts at 0 and grows by 1 on each exhaustive start. It wraps to 0 once it would reach runLen. A start in any other mode, or a reset, returns it to 0.
- R6: irqReq stays high until irqAck is sampled high while it is high. It is low in the cycle after that edge.
- R7: If irqAck is not seen in the 16 cycles that irqReq is high, irqReq drops and timeoutErr rises on the same edge. No memory access and no done pulse follow. timeoutErr stays high until the next accepted start clears it.
- R8: After the acknowledge edge, the first cycle drives memRd with memAddr equal to the selected address. The memory returns memRdata one cycle after memRd. The third cycle drives memWr to the same address, with memWdata equal to the read byte XOR (1 << bitIdx).
- R9: done is high for exactly one cycle, the cycle right after the memWr cycle (the fourth cycle after the acknowledge edge).
- R10: A start strobe that arrives while a run is in progress is ignored. The run keeps the instant and address it latched.
- R11: modeSel value 3 behaves as deterministic mode and, like it, returns the sweep offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Instant/location choice: 0 random, 1 deterministic, 2 exhaustive, 3 as deterministic |
| seed | input | 32 | Seed loaded into the pseudo-random source after reset |
| detTime | input | 16 | Fixed injection instant in cycles after start |
| detAddr | input | 8 | Fixed target address |
| bitIdx | input | 3 | Index of the bit to flip |
| runLen | input | 16 | Length of the run window that bounds random and swept instants |
| addrBase | input | 8 | First address of the random target window |
| addrSpan | input | 8 | Number of addresses in the random target window |
| start | input | 1 | Starts one injection run when idle |
| irqAck | input | 1 | Target acknowledge of the injection interrupt |
| memRdata | input | 8 | Read data from the shared memory, one cycle after memRd |
| irqReq | output | 1 | Injection interrupt request to the target |
| memAddr | output | 8 | Shared memory address |
| memRd | output | 1 | Shared memory read strobe |
| memWr | output | 1 | Shared memory write strobe |
| memWdata | output | 8 | Corrupted byte written back |
| done | output | 1 | One-cycle pulse after the write-back |
| timeoutErr | output | 1 | Set when the interrupt went unacknowledged |

## Verification
The bench goes after instant zero, where an off-by-one in the counter would show as an interrupt one cycle early or late. It also covers the exhaustive wrap at the run length and the reset of the sweep offset by a run in another mode; getting either wrong would make the sweep repeat or skip cycles. A zero seed is tested because a design that did not substitute it would lock the random source at zero and always hit the window base at instant zero. The bench also checks flips of bit 0 and bit 7, an acknowledge on the last allowed cycle against a missing acknowledge (a wrong timeout would drop the request early or write memory without permission), and a second start in mid-run, which a faulty design would let move the pending instant.

// File: rtl/upset_pkg.sv
package upset_pkg;

  typedef enum logic [1:0] {
    MODE_RAND  = 2'd0,
    MODE_DET   = 2'd1,
    MODE_SWEEP = 2'd2,
    MODE_ALT   = 2'd3
  } injMode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_COUNT = 3'd1,
    ST_IRQ   = 3'd2,
    ST_READ  = 3'd3,
    ST_CAPT  = 3'd4,
    ST_WRITE = 3'd5,
    ST_FIN   = 3'd6
  } ctrlState_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic latchSel;  // start accepted: choose instant, address, mask
    logic cntRun;    // advance the cycle counter
    logic capData;   // capture the read byte
  } dpStrobe_t;

endpackage

// File: rtl/upset_lfsr.sv
module upset_lfsr #(
  parameter int          LFSR_W = 32,
  parameter logic [31:0] TAPS   = 32'h80200003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LFSR_W-1:0] seed,
  input  logic              advance,
  output logic [LFSR_W-1:0] nextVal
);

  localparam logic [LFSR_W-1:0] TAP_MASK = TAPS[LFSR_W-1:0];

  logic [LFSR_W-1:0] stateQ;
  logic              needLoad;
  logic [LFSR_W-1:0] seedFix;
  logic [LFSR_W-1:0] baseVal;

  // an all-zero state would lock the register, so substitute 1
  assign seedFix = (seed == '0) ? LFSR_W'(1) : seed;
  assign baseVal = needLoad ? seedFix : stateQ;
  assign nextVal = baseVal[0] ? ((baseVal >> 1) ^ TAP_MASK) : (baseVal >> 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= LFSR_W'(1);
      needLoad <= 1'b1;
    end else begin
      needLoad <= 1'b0;
      if (advance)       stateQ <= nextVal;
      else if (needLoad) stateQ <= seedFix;
    end
  end

endmodule

// File: rtl/upset_datapath.sv
module upset_datapath
  import upset_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TIME_W = 16,
  parameter int LFSR_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        modeSel,
  input  logic [LFSR_W-1:0] seed,
  input  logic [TIME_W-1:0] detTime,
  input  logic [ADDR_W-1:0] detAddr,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [TIME_W-1:0] runLen,
  input  logic [ADDR_W-1:0] addrBase,
  input  logic [ADDR_W-1:0] addrSpan,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int TPROD_W = 2 * TIME_W;
  localparam int APROD_W = 2 * ADDR_W;

  injMode_e          mode;
  logic [LFSR_W-1:0] lfsrNext;
  logic              unusedLfsr;
  logic              lfsrStep;

  logic [TIME_W-1:0] sweepQ, sweepCur;
  logic [TIME_W:0]   sweepInc;
  logic [TIME_W-1:0] sweepNext;

  logic [TPROD_W-1:0] timeProd;
  logic [APROD_W-1:0] addrProd;
  logic [TIME_W-1:0]  randInst;
  logic [ADDR_W-1:0]  randAddr;

  logic [TIME_W-1:0] instSel;
  logic [ADDR_W-1:0] addrSel;
  logic [DATA_W-1:0] maskSel;

  logic [TIME_W-1:0] instQ, cntQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] maskQ, dataQ;

  assign mode     = injMode_e'(modeSel);
  assign lfsrStep = strobe.latchSel && (mode == MODE_RAND);

  upset_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
    .clk     (clk),
    .rstN    (rstN),
    .seed    (seed),
    .advance (lfsrStep),
    .nextVal (lfsrNext)
  );

  assign unusedLfsr = ^lfsrNext;

  // scale the random fields into their windows by multiply-high
  assign timeProd = {{TIME_W{1'b0}}, lfsrNext[TIME_W-1:0]} * {{TIME_W{1'b0}}, runLen};
  assign addrProd = {{ADDR_W{1'b0}}, lfsrNext[LFSR_W-1 -: ADDR_W]} * {{ADDR_W{1'b0}}, addrSpan};
  assign randInst = timeProd[TPROD_W-1:TIME_W];
  assign randAddr = addrBase + addrProd[APROD_W-1:ADDR_W];

  // exhaustive sweep offset
  assign sweepCur  = (sweepQ >= runLen) ? '0 : sweepQ;
  assign sweepInc  = {1'b0, sweepCur} + (TIME_W+1)'(1);
  assign sweepNext = (sweepInc >= {1'b0, runLen}) ? '0 : sweepInc[TIME_W-1:0];

  always_comb begin
    unique case (mode)
      MODE_RAND: begin
        instSel = randInst;
        addrSel = randAddr;
      end
      MODE_SWEEP: begin
        instSel = sweepCur;
        addrSel = detAddr;
      end
      default: begin
        instSel = detTime;
        addrSel = detAddr;
      end
    endcase
  end

  // one-hot mask, one decoder bit per data bit
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign maskSel[g] = (bitIdx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepQ <= '0;
      instQ  <= '0;
      addrQ  <= '0;
      maskQ  <= '0;
    end else if (strobe.latchSel) begin
      sweepQ <= (mode == MODE_SWEEP) ? sweepNext : '0;
      instQ  <= instSel;
      addrQ  <= addrSel;
      maskQ  <= maskSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cntQ <= '0;
    else if (strobe.latchSel) cntQ <= '0;
    else if (strobe.cntRun)   cntQ <= cntQ + TIME_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataQ <= '0;
    else if (strobe.capData) dataQ <= memRdata;
  end

  assign hit      = (cntQ == instQ);
  assign memAddr  = addrQ;
  assign memWdata = dataQ ^ maskQ;

endmodule

// File: rtl/upset_ctrl.sv
module upset_ctrl
  import upset_pkg::*;
#(
  parameter int ACK_TIMEOUT = 16,
  localparam int TO_W = $clog2(ACK_TIMEOUT + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      irqAck,
  input  logic      hit,
  output dpStrobe_t strobe,
  output logic      irqReq,
  output logic      memRd,
  output logic      memWr,
  output logic      done,
  output logic      timeoutErr
);

  ctrlState_e stQ, stNext;
  logic [TO_W-1:0] waitCnt;
  logic            waitExpired;
  logic            setErr;

  assign waitExpired = (waitCnt == TO_W'(ACK_TIMEOUT - 1));

  always_comb begin
    stNext = stQ;
    setErr = 1'b0;
    unique case (stQ)
      ST_IDLE:  if (start) stNext = ST_COUNT;
      ST_COUNT: if (hit) stNext = ST_IRQ;
      ST_IRQ: begin
        if (irqAck) stNext = ST_READ;
        else if (waitExpired) begin
          stNext = ST_IDLE;
          setErr = 1'b1;
        end
      end
      ST_READ:  stNext = ST_CAPT;
      ST_CAPT:  stNext = ST_WRITE;
      ST_WRITE: stNext = ST_FIN;
      ST_FIN:   stNext = ST_IDLE;
      default:  stNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.latchSel = (stQ == ST_IDLE) && start;
    strobe.cntRun   = (stQ == ST_COUNT) && !hit;
    strobe.capData  = (stQ == ST_CAPT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              waitCnt <= '0;
    else if (stQ == ST_IRQ) waitCnt <= waitCnt + TO_W'(1);
    else                    waitCnt <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timeoutErr <= 1'b0;
    else if (strobe.latchSel) timeoutErr <= 1'b0;
    else if (setErr)          timeoutErr <= 1'b1;
  end

  assign irqReq = (stQ == ST_IRQ);
  assign memRd  = (stQ == ST_READ);
  assign memWr  = (stQ == ST_WRITE);
  assign done   = (stQ == ST_FIN);

endmodule

// File: rtl/upset_inject_sched.sv
module upset_inject_sched
  import upset_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int TIME_W      = 16,
  parameter int LFSR_W      = 32,
  parameter int ACK_TIMEOUT = 16,
  localparam int IDX_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [LFSR_W-1:0] seed,
  input  logic [TIME_W-1:0] detTime,
  input  logic [ADDR_W-1:0] detAddr,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [TIME_W-1:0] runLen,
  input  logic [ADDR_W-1:0] addrBase,
  input  logic [ADDR_W-1:0] addrSpan,
  input  logic              start,
  input  logic              irqAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              irqReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  output logic              done,
  output logic              timeoutErr
);

  dpStrobe_t strobe;
  logic      hit;

  upset_ctrl #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .irqAck     (irqAck),
    .hit        (hit),
    .strobe     (strobe),
    .irqReq     (irqReq),
    .memRd      (memRd),
    .memWr      (memWr),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

  upset_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TIME_W (TIME_W),
    .LFSR_W (LFSR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .modeSel  (modeSel),
    .seed     (seed),
    .detTime  (detTime),
    .detAddr  (detAddr),
    .bitIdx   (bitIdx),
    .runLen   (runLen),
    .addrBase (addrBase),
    .addrSpan (addrSpan),
    .memRdata (memRdata),
    .hit      (hit),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/upset_inject_sched_chk.sv
module upset_inject_sched_chk #(
  parameter int ACK_TIMEOUT = 16,
  localparam int HC_W = $clog2(ACK_TIMEOUT + 2)
) (
  input logic clk,
  input logic rstN,
  input logic irqAck,
  input logic irqReq,
  input logic memRd,
  input logic memWr,
  input logic done,
  input logic timeoutErr
);

  logic [HC_W-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       highCnt <= '0;
    else if (irqReq) highCnt <= highCnt + HC_W'(1);
    else             highCnt <= '0;
  end

  // R7: the request is never held past the timeout window
  a_r7_irq_bounded: assert property (@(posedge clk) disable iff (!rstN)
    highCnt <= HC_W'(ACK_TIMEOUT));

  // R7: the error rises together with the request being withdrawn
  a_r7_err_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> $fell(irqReq));

  // R6: an acknowledged request is gone on the next cycle
  a_r6_ack_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck) |=> !irqReq);

  // R6: the request only falls on an acknowledge or on the timeout
  a_r6_no_silent_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq) |-> ($past(irqAck) || $rose(timeoutErr)));

  // R8: the interrupt and the memory strobes never overlap
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && (memRd || memWr)) && !(memRd && memWr));

  // R8: a write comes two cycles after a read
  a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memRd, 2));

  // R9: done lasts one cycle and follows the write
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memWr));

endmodule

bind upset_inject_sched upset_inject_sched_chk #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .irqAck     (irqAck),
  .irqReq     (irqReq),
  .memRd      (memRd),
  .memWr      (memWr),
  .done       (done),
  .timeoutErr (timeoutErr)
);

// File: tb/upset_inject_sched_bench.sv
`timescale 1ns/1ps
module upset_inject_sched_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'd1;
  logic [31:0] seed = 32'd0;
  logic [15:0] detTime = 16'd0;
  logic [7:0]  detAddr = 8'd0;
  logic [2:0]  bitIdx = 3'd0;
  logic [15:0] runLen = 16'd8;
  logic [7:0]  addrBase = 8'd0;
  logic [7:0]  addrSpan = 8'd16;
  logic        start = 1'b0;
  logic        irqAck = 1'b0;
  logic [7:0]  memRdata;
  logic        irqReq, memRd, memWr, done, timeoutErr;
  logic [7:0]  memAddr, memWdata;

  int total = 0;
  int bad = 0;

  logic [7:0]  memArr [256];
  logic [7:0]  expMem [256];
  logic [7:0]  rdQ = 8'd0;
  logic [31:0] lfsrM;
  logic [15:0] sweepM;

  always #2.5 clk = ~clk;

  upset_inject_sched u_upset_inject_sched (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .seed(seed), .detTime(detTime),
    .detAddr(detAddr), .bitIdx(bitIdx), .runLen(runLen), .addrBase(addrBase),
    .addrSpan(addrSpan), .start(start), .irqAck(irqAck), .memRdata(memRdata),
    .irqReq(irqReq), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .done(done), .timeoutErr(timeoutErr)
  );

  // shared memory with one cycle of read latency
  always @(posedge clk) begin
    if (memRd) rdQ <= memArr[memAddr];
    if (memWr) memArr[memAddr] <= memWdata;
  end
  assign memRdata = rdQ;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stepL(input logic [31:0] x);
    logic [31:0] y;
    y = x >> 1;
    if (x[0]) y = y ^ 32'h80200003;
    return y;
  endfunction

  task automatic doReset(input logic [31:0] s);
    seed = s;
    start = 1'b0;
    irqAck = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!irqReq && !memRd && !memWr && !done && !timeoutErr, "R1 outputs in reset",
        {27'd0, irqReq, memRd, memWr, done, timeoutErr}, 32'd0);
    rstN = 1'b1;
    lfsrM  = (s == 32'd0) ? 32'd1 : s;
    sweepM = 16'd0;
    @(negedge clk);
    chk(!irqReq && !memRd && !memWr && !done && !timeoutErr, "R1 outputs after reset",
        {27'd0, irqReq, memRd, memWr, done, timeoutErr}, 32'd0);
  endtask

  // one injection run with expected values computed from the requirements
  task automatic runOne(input logic [1:0] m, input logic [15:0] dT, input logic [7:0] dA,
                        input logic [2:0] bi, input int ackDly, input bit noAck,
                        input bit glitch, input string tag);
    logic [15:0] expInst;
    logic [7:0]  expAddr;
    logic [31:0] prod;
    logic [7:0]  expW;
    int k;
    int hc;
    case (m)
      2'd0: begin
        lfsrM   = stepL(lfsrM);
        prod    = {16'd0, lfsrM[15:0]} * {16'd0, runLen};
        expInst = prod[31:16];
        prod    = {24'd0, lfsrM[31:24]} * {24'd0, addrSpan};
        expAddr = addrBase + prod[15:8];
        sweepM  = 16'd0;
      end
      2'd2: begin
        if (sweepM >= runLen) sweepM = 16'd0;
        expInst = sweepM;
        expAddr = dA;
        sweepM  = ({16'd0, sweepM} + 32'd1 >= {16'd0, runLen}) ? 16'd0 : sweepM + 16'd1;
      end
      default: begin
        expInst = dT;
        expAddr = dA;
        sweepM  = 16'd0;
      end
    endcase
    modeSel = m;
    detTime = dT;
    detAddr = dA;
    bitIdx  = bi;
    start   = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      if (k == 0) begin
        start = 1'b0;
        chk(timeoutErr == 1'b0, {"R7 error cleared by start ", tag}, {31'd0, timeoutErr}, 32'd0);
      end
      k++;
      if (glitch && k == 2) begin
        detTime = dT + 16'd3;
        detAddr = dA ^ 8'h5A;
        start   = 1'b1;
      end
      if (glitch && k == 3) begin
        start   = 1'b0;
        detTime = dT;
        detAddr = dA;
      end
    end while (!irqReq && k < int'(expInst) + 60);
    chk(k == int'(expInst) + 2, {"R2 interrupt instant ", tag}, k, expInst + 32'd2);
    if (glitch) chk(k == int'(expInst) + 2, {"R10 busy start ignored ", tag}, k, expInst + 32'd2);
    if (noAck) begin
      hc = 0;
      while (irqReq && hc < 40) begin
        if (memRd || memWr) chk(1'b0, "R7 memory touched while waiting", 32'd1, 32'd0);
        hc++;
        @(negedge clk);
      end
      chk(hc == 16, {"R7 request high cycles ", tag}, hc, 32'd16);
      chk(timeoutErr == 1'b1, {"R7 error flag ", tag}, {31'd0, timeoutErr}, 32'd1);
      for (int i = 0; i < 6; i++) begin
        if (memRd || memWr || done || irqReq)
          chk(1'b0, "R7 activity after timeout", {28'd0, memRd, memWr, done, irqReq}, 32'd0);
        @(negedge clk);
      end
      chk(timeoutErr == 1'b1, "R7 error stays set", {31'd0, timeoutErr}, 32'd1);
    end else begin
      for (int i = 0; i < ackDly; i++) begin
        @(negedge clk);
        if (!irqReq) chk(1'b0, {"R6 request held until ack ", tag}, 32'd0, 32'd1);
      end
      irqAck = 1'b1;
      @(negedge clk);
      irqAck = 1'b0;
      chk(!irqReq, {"R6 request drops after ack ", tag}, {31'd0, irqReq}, 32'd0);
      chk(memRd && memAddr == expAddr, {"R8 read address ", tag}, {23'd0, memRd, memAddr}, {24'd1, expAddr});
      @(negedge clk);
      @(negedge clk);
      expW = expMem[expAddr] ^ (8'd1 << bi);
      chk(memWr && memAddr == expAddr, {"R8 write address ", tag}, {23'd0, memWr, memAddr}, {24'd1, expAddr});
      chk(memWdata == expW, {"R8 write data ", tag}, {24'd0, memWdata}, {24'd0, expW});
      if (m == 2'd0) chk(memAddr == expAddr, {"R4 random address ", tag}, {24'd0, memAddr}, {24'd0, expAddr});
      if (m == 2'd2) chk(memAddr == dA, {"R5 sweep address ", tag}, {24'd0, memAddr}, {24'd0, dA});
      expMem[expAddr] = expW;
      @(negedge clk);
      chk(done && !memWr, {"R9 done after write ", tag}, {31'd0, done}, 32'd1);
      @(negedge clk);
      chk(!done, {"R9 done one cycle ", tag}, {31'd0, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] rm;
    for (int i = 0; i < 256; i++) begin
      memArr[i] = 8'(i * 37 + 5);
      expMem[i] = 8'(i * 37 + 5);
    end
    void'($urandom(32'd20240611));

    // zero seed: random source starts from 1
    doReset(32'd0);
    runLen = 16'd40; addrBase = 8'h20; addrSpan = 8'd32;
    runOne(2'd0, 16'd0, 8'd0, 3'd0, 0, 1'b0, 1'b0, "R3 zero seed");
    runOne(2'd0, 16'd0, 8'd0, 3'd5, 1, 1'b0, 1'b0, "R3 second step");

    doReset(32'hACE12468);
    // deterministic, instant zero, bit 7 and bit 0
    runOne(2'd1, 16'd0, 8'h10, 3'd7, 0, 1'b0, 1'b0, "R2 instant zero");
    runOne(2'd1, 16'd9, 8'hFF, 3'd0, 2, 1'b0, 1'b0, "R2 top address");
    // acknowledge on the last allowed cycle
    runOne(2'd1, 16'd3, 8'h33, 3'd2, 15, 1'b0, 1'b0, "R6 late ack");
    // missing acknowledge, then error clears on the next run
    runOne(2'd1, 16'd2, 8'h34, 3'd1, 0, 1'b1, 1'b0, "R7 timeout");
    runOne(2'd1, 16'd1, 8'h34, 3'd1, 0, 1'b0, 1'b0, "R7 recover");
    // busy start ignored
    runOne(2'd1, 16'd8, 8'h40, 3'd4, 0, 1'b0, 1'b1, "R10 glitch");
    // exhaustive sweep with wrap at run length 3
    runLen = 16'd3;
    for (int i = 0; i < 5; i++) runOne(2'd2, 16'd0, 8'h50, 3'(i), 0, 1'b0, 1'b0, "R5 sweep");
    runOne(2'd3, 16'd4, 8'h51, 3'd3, 0, 1'b0, 1'b0, "R11 mode three");
    runOne(2'd2, 16'd0, 8'h50, 3'd6, 0, 1'b0, 1'b0, "R5 sweep restart");
    // random with empty span and zero run length
    runLen = 16'd0; addrSpan = 8'd0; addrBase = 8'h77;
    runOne(2'd0, 16'd0, 8'd0, 3'd3, 0, 1'b0, 1'b0, "R4 empty window");

    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      rm       = 2'($urandom % 4);
      runLen   = 16'(1 + $urandom % 40);
      addrBase = 8'($urandom);
      addrSpan = 8'($urandom);
      runOne(rm, 16'($urandom % 30), 8'($urandom), 3'($urandom), int'($urandom % 10),
             ($urandom % 8) == 0, (rm == 2'd1) && ($urandom % 3 == 0), "R4 random mix");
    end

    begin
      int diffs;
      diffs = 0;
      for (int i = 0; i < 256; i++) if (memArr[i] != expMem[i]) diffs++;
      chk(diffs == 0, "R8 memory image", diffs, 32'd0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule